// File: doc/BRIEF.md
# Flash Program/Erase Control Register

This block is a byte-wide, memory-mapped control register. It sits beside an embedded flash array and decides which operation the array performs: programming, erasing one page, or erasing the whole array. It also decides when the high-voltage charge pump is switched on. A bus master writes the register at one decoded address and reads it back combinationally. The same bus also carries writes into the flash array's address window. The block watches those writes because one of them is part of the arming sequence.

Three select bits are held in storage: program, erase and whole-array. An interlock rejects any write that asks for program and erase together. The high-voltage bit is not stored as a plain flip-flop. It is the output of a four-state sequence tracker, with these states:

- `ST_IDLE`: no operation is selected.
- `ST_ARMED`: program or erase is selected, but no array write has been seen yet.
- `ST_LATCHED`: a select is held and an array write has been seen.
- `ST_HIGHV`: high voltage is on.

The tracker has these transitions:

- `IDLE→ARMED`: an accepted write selects program or erase.
- `ARMED→LATCHED`: a bus write lands in the array window.
- `LATCHED→HIGHV`: an accepted write keeps a select and requests high voltage.
- `HIGHV→LATCHED`: an accepted write keeps a select and drops the high-voltage request.
- `ARMED/LATCHED/HIGHV→IDLE`: an accepted write clears both program and erase.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset, and after any later reset, the register reads 0x00 and every operation and high-voltage output is low.
- R2: Bits 7..4 always read 0, and the values written to them have no effect on the other bits.
- R3: A register write with bit 1 (erase) and bit 0 (program) both 1 leaves the whole register, including bit 3, unchanged.
- R4: An accepted register write stores bit 2 (whole-array), bit 1 (erase) and bit 0 (program) from the write data at the clock edge.
- R5: Bit 3 (high voltage) becomes 1 only if both conditions below hold; otherwise bit 3 stays 0 and bits 2..0 update normally.
  - Program or erase was already 1 before the write.
  - An array write has been recorded since then.
- R6: An array write is a bus write whose address lies within ARRAY_LO..ARRAY_HI (default 0x8000..0xFDFF). A write outside that window is not recorded. Once program and erase are both 0, the record is lost and a new array write is needed.
- R7: A write that clears both program and erase forces bit 3 to 0 at that same edge, even if bit 3 is requested.
- R8: pump_on and array_hv both equal bit 3.
- R9: The operation outputs decode the register as follows.
  - op_prog is bit 0.
  - op_page_erase is erase with whole-array clear.
  - op_mass_erase is erase with whole-array set.
- R10: bus_rdata shows the register only while bus_addr equals REG_ADDR (default 0xFF88); at any other address it is 0.
- R11: A write that keeps a select but clears bit 3 turns high voltage off without losing the array-write record, so bit 3 can be set again with no new array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_we | input | 1 | Active-high write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| op_prog | output | 1 | Program operation selected |
| op_page_erase | output | 1 | Single-page erase selected |
| op_mass_erase | output | 1 | Whole-array erase selected |
| pump_on | output | 1 | Charge pump enable |
| array_hv | output | 1 | High voltage routed to the array |

## Verification
The hardest condition to reach from the ports is a legal high-voltage grant. It needs three ordered bus actions: first a select write, then a write into the array window, then a second register write that requests high voltage.

The vector table walks that order for program and for erase. It also walks the variants that must fail:
- a high-voltage request before any array write;
- a request after the selects were cleared;
- array writes just outside the window.

Holding high voltage while toggling bit 3 exercises the LATCHED/HIGHV loop without a fresh array write.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_LATCHED,
        ST_HIGHV
    } seq_state_e;

    localparam int BIT_HV    = 3;
    localparam int BIT_MASS  = 2;
    localparam int BIT_ERASE = 1;
    localparam int BIT_PROG  = 0;
    localparam int IMPL_BITS = 4;
endpackage

// File: rtl/flash_ctl_decode.sv
module flash_ctl_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF88,
    parameter logic [ADDR_W-1:0] ARRAY_LO = 16'h8000,
    parameter logic [ADDR_W-1:0] ARRAY_HI = 16'hFDFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              reg_sel,
    output logic              reg_wr,
    output logic              array_wr
);
    always_comb begin
        reg_sel  = (addr == REG_ADDR);
        reg_wr   = we && reg_sel;
        array_wr = we && (addr >= ARRAY_LO) && (addr <= ARRAY_HI);
    end
endmodule

// File: rtl/flash_ctl_bits.sv
module flash_ctl_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_wr,
    input  logic wr_mass,
    input  logic wr_erase,
    input  logic wr_prog,
    output logic accept,
    output logic sel_mass,
    output logic sel_erase,
    output logic sel_prog
);
    // interlock: program and erase together is refused outright
    always_comb accept = reg_wr && !(wr_erase && wr_prog);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_mass  <= 1'b0;
            sel_erase <= 1'b0;
            sel_prog  <= 1'b0;
        end else if (accept) begin
            sel_mass  <= wr_mass;
            sel_erase <= wr_erase;
            sel_prog  <= wr_prog;
        end
    end
endmodule

// File: rtl/flash_ctl_seq.sv
module flash_ctl_seq
    import flash_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic new_sel,
    input  logic hv_req,
    input  logic array_wr,
    output logic hv
);
    seq_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept && new_sel) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (accept)        nxt = new_sel ? ST_ARMED : ST_IDLE;
                else if (array_wr) nxt = ST_LATCHED;
            end
            ST_LATCHED, ST_HIGHV: begin
                if (accept) begin
                    if (!new_sel)    nxt = ST_IDLE;
                    else if (hv_req) nxt = ST_HIGHV;
                    else             nxt = ST_LATCHED;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb hv = (state == ST_HIGHV);
endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
    import flash_ctl_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF88,
    parameter logic [ADDR_W-1:0] ARRAY_LO = 16'h8000,
    parameter logic [ADDR_W-1:0] ARRAY_HI = 16'hFDFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              op_prog,
    output logic              op_page_erase,
    output logic              op_mass_erase,
    output logic              pump_on,
    output logic              array_hv
);
    localparam int PAD_W = DATA_W - IMPL_BITS;

    logic reg_sel, reg_wr, array_wr, accept;
    logic sel_mass, sel_erase, sel_prog, hv;

    flash_ctl_decode #(
        .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
        .ARRAY_LO(ARRAY_LO), .ARRAY_HI(ARRAY_HI)
    ) u_dec (
        .addr(bus_addr), .we(bus_we),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .array_wr(array_wr)
    );

    flash_ctl_bits u_bits (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
        .wr_mass(bus_wdata[BIT_MASS]), .wr_erase(bus_wdata[BIT_ERASE]),
        .wr_prog(bus_wdata[BIT_PROG]), .accept(accept),
        .sel_mass(sel_mass), .sel_erase(sel_erase), .sel_prog(sel_prog)
    );

    flash_ctl_seq u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .new_sel(bus_wdata[BIT_ERASE] || bus_wdata[BIT_PROG]),
        .hv_req(bus_wdata[BIT_HV]), .array_wr(array_wr), .hv(hv)
    );

    always_comb begin
        bus_rdata     = reg_sel ? {{PAD_W{1'b0}}, hv, sel_mass, sel_erase, sel_prog}
                                : '0;
        op_prog       = sel_prog;
        op_page_erase = sel_erase && !sel_mass;
        op_mass_erase = sel_erase && sel_mass;
        pump_on       = hv;
        array_hv      = hv;
    end
endmodule

// File: rtl/flash_ctl_chk.sv
module flash_ctl_chk #(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF88
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              op_prog,
    input logic              op_page_erase,
    input logic              op_mass_erase,
    input logic              pump_on,
    input logic              array_hv
);
    logic any_sel;
    assign any_sel = op_prog || op_page_erase || op_mass_erase;

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_prog && (op_page_erase || op_mass_erase)));

    p_both_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_ADDR && bus_wdata[1] && bus_wdata[0])
        |=> $stable({op_prog, op_page_erase, op_mass_erase, pump_on}));

    p_hv_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pump_on |-> any_sel);

    p_hv_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_on) |-> $past(any_sel));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_ADDR && bus_wdata[1:0] == 2'b00)
        |=> !pump_on);

    p_pump_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pump_on == array_hv);

    p_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_ADDR) |-> (bus_rdata[DATA_W-1:4] == '0));

    p_other_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |-> (bus_rdata == '0));
endmodule

bind flash_ctl_reg flash_ctl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .op_prog(op_prog),
    .op_page_erase(op_page_erase), .op_mass_erase(op_mass_erase),
    .pump_on(pump_on), .array_hv(array_hv)
);

// File: tb/test_flash_ctl_reg.sv
module test_flash_ctl_reg;
    localparam logic [15:0] REG_A = 16'hFF88;
    localparam logic [15:0] ARR_A = 16'h9000;

    typedef struct packed {
        logic       to_array;
        logic [7:0] wdata;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'hF0, 8'h00},  // R2 upper bits ignored
        '{1'b0, 8'h01, 8'h01},  // R4 program select
        '{1'b0, 8'h09, 8'h01},  // R5 hv refused, no array write yet
        '{1'b1, 8'h00, 8'h01},  // R6 array write recorded
        '{1'b0, 8'h09, 8'h09},  // R5 hv granted
        '{1'b0, 8'h03, 8'h09},  // R3 both selects refused
        '{1'b0, 8'h01, 8'h01},  // R11 hv dropped, select kept
        '{1'b0, 8'h09, 8'h09},  // R11 hv again, no new array write
        '{1'b0, 8'h00, 8'h00},  // R7 clear selects
        '{1'b0, 8'h09, 8'h01},  // R6 record lost after clear
        '{1'b0, 8'h06, 8'h06},  // R9 mass erase select
        '{1'b1, 8'h00, 8'h06},  // R6 array write
        '{1'b0, 8'h0E, 8'h0E},  // R5 hv on erase
        '{1'b0, 8'hF2, 8'h02},  // R9 page erase, R2 upper ignored
        '{1'b0, 8'h0A, 8'h0A},  // R11 hv back on page erase
        '{1'b0, 8'h08, 8'h00}   // R7 hv requested but selects cleared
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = REG_A;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        op_prog, op_page_erase, op_mass_erase, pump_on, array_hv;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    flash_ctl_reg i_flash_ctl_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .op_prog(op_prog),
        .op_page_erase(op_page_erase), .op_mass_erase(op_mass_erase),
        .pump_on(pump_on), .array_hv(array_hv)
    );

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = REG_A;
        #1;
    endtask

    // compares read-back plus decoded outputs against the expected register value
    task automatic check_reg(input logic [7:0] exp, input string req);
        logic [12:0] act, want;
        act  = {bus_rdata, op_prog, op_page_erase, op_mass_erase, pump_on, array_hv};
        want = {exp, exp[0], exp[1] & ~exp[2], exp[1] & exp[2], exp[3], exp[3]};
        n_checks++;
        if (act !== want) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, want);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check_reg(8'h00, "R1 reset state");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i].to_array ? ARR_A : REG_A, VECS[i].wdata);
            check_reg(VECS[i].exp, $sformatf("R2-R11 vector %0d", i));
        end

        // R10: other address reads zero while register holds a value
        bus_write(REG_A, 8'h01);
        @(negedge clk);
        bus_addr = 16'h1234;
        #1;
        n_checks++;
        if (bus_rdata !== 8'h00) begin
            n_fail++;
            $display("FAIL R10 foreign address: actual %h expected 00", bus_rdata);
        end
        bus_addr = REG_A;
        #1;
        check_reg(8'h01, "R10 register still held");

        // R6: writes just outside the array window are not recorded
        bus_write(16'h7FFF, 8'h00);
        bus_write(16'hFE00, 8'h00);
        bus_write(REG_A, 8'h09);
        check_reg(8'h01, "R6 outside window");

        // R6: upper window edge counts
        bus_write(16'hFDFF, 8'h00);
        bus_write(REG_A, 8'h09);
        check_reg(8'h09, "R6 window edge");

        // R1: reset during high voltage
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reg(8'h00, "R1 reset while hv");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: after reset the array-write record is gone
        bus_write(REG_A, 8'h09);
        check_reg(8'h01, "R1 record cleared by reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule